// File: doc/BRIEF.md
# Line Printer Carriage Controller

This block carries out print and paper-motion commands for a 132-column line printer whose vertical spacing comes from a loaded format memory. Each row of that memory holds one flag per channel (12 channels). Channel 0 marks the top of a form. The block keeps three counters: the print column, the line pointer into the format memory, and a 12-bit page counter. It turns each command into a stream of output characters (printable codes, carriage return, newline 0x0A and form feed 0x0C) that the printer mechanism consumes.

Commands arrive on a valid/ready port. A command is taken only when `cmd_ready` is high, and `cmd_ready` is high only while the controller is idle. A multi-character result, such as a run of spaces or newlines, leaves on the output port one character per accepted transfer. The output port follows valid/ready rules: `out_valid` never waits on `out_ready`. While `out_valid` is high and `out_ready` is low, `out_char` holds its value and nothing advances. The format memory itself sits outside the block and is read combinationally through `fmt_addr`/`fmt_row`. Its active length and the page counter are loaded through plain strobes, and both loads take effect only while the block is idle.

Top module: `lp_carriage`

## Requirements
- R1: After reset the column, line pointer, format length and page counter are 0, `page_zero` and `stop_req` are low, `out_valid` is low and `cmd_ready` is high.
- R2: Print (op 0) masks the argument to 7 bits. A code 0x20 and above is emitted as is; any other control code not named below is emitted as a space 0x20. Each emitted character adds one to the column.
- R3: Print of 0x00 produces no output and changes no counter.
- R4: Print of 0x0D emits 0x0D and sets the column to 0.
- R5: Print of 0x09 emits spaces up to the next multiple of 8. When the column is 128 or more, it first performs a one-line advance and then emits 8 spaces.
- R6: A printable character or space that arrives at column 132 or more is preceded by a one-line advance, so the column ends at 1.
- R7: Slew (op 1) by N>0 emits N newlines, clears the column and steps the line pointer N times, wrapping to 0 at the format length. N=0 has no effect. Print of 0x0A is a slew by 1.
- R8: After any line advance, if the format row at the pointer has channel 0 set, the page counter decrements modulo 4096. A result of 0 sets `page_zero` and requests a stop. Any other result clears `page_zero`. The page counter and `page_zero` do not change otherwise.
- R9: Skip (op 2) to channel C>0 steps the pointer with wrap until a row with bit C is found after i+1 steps. It then emits i+1 newlines without stepping the pointer again, clears the column and applies the R8 check.
- R10: A skip channel argument above 11 selects channel 7.
- R11: Skip to channel 0, which print of 0x0C also performs, emits a newline only if the column is non-zero, then emits 0x0C, then decrements the page counter as in R8.
- R12: If no row within one full format length carries the channel bit, nothing is emitted, the format length becomes 0 and a stop is requested.
- R13: `stop_req` is a one-cycle pulse in the last cycle of a command that requested a stop. `out_char` holds stable while `out_valid` is high and `out_ready` is low, and no output is offered while `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command taken this cycle if valid |
| cmd_op | input | 2 | 0 print, 1 slew, 2 skip to channel, 3 no operation |
| cmd_arg | input | 8 | Character, line count or channel number |
| out_valid | output | 1 | Output character offered |
| out_ready | input | 1 | Printer accepts the offered character |
| out_char | output | 7 | Output character code |
| fmt_addr | output | 8 | Format memory row address |
| fmt_row | input | 12 | Channel flags of the addressed row, bit n is channel n |
| fmt_len_load | input | 1 | Load the format length (idle only), pointer returns to 0 |
| fmt_len_value | input | 8 | New format length, clamped to the memory depth |
| page_load | input | 1 | Load the page counter (idle only) |
| page_value | input | 12 | New page count |
| column | output | 8 | Current print column |
| line_ptr | output | 8 | Current format row pointer |
| fmt_len | output | 8 | Current format length, 0 means invalid |
| page_count | output | 12 | Current page count |
| page_zero | output | 1 | Last top-of-form decrement reached zero |
| stop_req | output | 1 | Stop request pulse |

## Verification
Two functions can land in the same clock edge: a page-counter load and the acceptance of a command that will later decrement that counter at a top-of-form row. The bench drives `page_load` and `cmd_valid` together in one cycle, several times with small page values. It expects the command to work from the newly loaded count, so a load of 1 followed by a slew onto a channel-0 row must raise `page_zero` and `stop_req`. Output back-pressure is mixed in on every command by driving `out_ready` randomly, and the collected character stream must match the bench model exactly.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    OP_PRINT = 2'd0,
    OP_SLEW  = 2'd1,
    OP_SKIP  = 2'd2,
    OP_NONE  = 2'd3
  } lpc_op_e;

  typedef enum logic [1:0] {
    K_NOP  = 2'd0,
    K_LF   = 2'd1,
    K_FF   = 2'd2,
    K_EMIT = 2'd3
  } lpc_kind_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SEARCH = 3'd1,
    S_NL     = 3'd2,
    S_FF     = 3'd3,
    S_TOF    = 3'd4,
    S_CHR    = 3'd5,
    S_FIN    = 3'd6
  } lpc_state_e;

  localparam logic [6:0] CH_NUL = 7'h00;
  localparam logic [6:0] CH_TAB = 7'h09;
  localparam logic [6:0] CH_LF  = 7'h0A;
  localparam logic [6:0] CH_FF  = 7'h0C;
  localparam logic [6:0] CH_CR  = 7'h0D;
  localparam logic [6:0] CH_SP  = 7'h20;

  localparam int FALLBACK_CHAN = 7;

endpackage

// File: rtl/lpc_char_decode.sv
module lpc_char_decode
  import lpc_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int LINE_COLS = 132,
  parameter int TAB_STOP  = 8
) (
  input  logic [6:0]       code,
  input  logic [COL_W-1:0] col,
  output lpc_kind_e        kind,
  output logic             pre_nl,
  output logic [6:0]       emit_char,
  output logic [COL_W-1:0] rep,
  output logic             is_cr
);
  localparam int TAB_B     = $clog2(TAB_STOP);
  localparam int TAB_LIMIT = (LINE_COLS / TAB_STOP) * TAB_STOP;

  always_comb begin
    kind      = K_EMIT;
    pre_nl    = 1'b0;
    emit_char = code;
    rep       = COL_W'(1);
    is_cr     = 1'b0;
    if (code == CH_NUL) begin
      kind = K_NOP;
    end else if (code == CH_LF) begin
      kind = K_LF;
    end else if (code == CH_FF) begin
      kind = K_FF;
    end else if (code == CH_CR) begin
      is_cr = 1'b1;
    end else if (code == CH_TAB) begin
      emit_char = CH_SP;
      if (col >= COL_W'(TAB_LIMIT)) begin
        pre_nl = 1'b1;
        rep    = COL_W'(TAB_STOP);
      end else begin
        rep = COL_W'(TAB_STOP) - COL_W'(col[TAB_B-1:0]);
      end
    end else begin
      if (code < CH_SP) emit_char = CH_SP;
      if (col >= COL_W'(LINE_COLS)) pre_nl = 1'b1;
    end
  end

endmodule

// File: rtl/lpc_page_ctr.sv
module lpc_page_ctr #(
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_val,
  input  logic              dec,
  output logic [PAGE_W-1:0] count,
  output logic              zero,
  output logic              dec_hits_zero
);
  assign dec_hits_zero = dec && (count == PAGE_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      zero  <= 1'b0;
    end else if (load) begin
      count <= load_val;
    end else if (dec) begin
      count <= count - PAGE_W'(1);
      zero  <= (count == PAGE_W'(1));
    end
  end

  // R8
  zero_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && count == PAGE_W'(1)) |=> (zero && count == '0));

  // R8
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && count != PAGE_W'(1)) |=> !zero);

endmodule

// File: rtl/lp_carriage.sv
module lp_carriage
  import lpc_pkg::*;
#(
  parameter int FMT_DEPTH = 143,
  parameter int CHAN_N    = 12,
  parameter int PAGE_W    = 12,
  parameter int LINE_COLS = 132,
  parameter int TAB_STOP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_arg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [6:0]        out_char,
  output logic [7:0]        fmt_addr,
  input  logic [11:0]       fmt_row,
  input  logic              fmt_len_load,
  input  logic [7:0]        fmt_len_value,
  input  logic              page_load,
  input  logic [11:0]       page_value,
  output logic [7:0]        column,
  output logic [7:0]        line_ptr,
  output logic [7:0]        fmt_len,
  output logic [11:0]       page_count,
  output logic              page_zero,
  output logic              stop_req
);
  localparam int PTR_W = 8;
  localparam int COL_W = 8;
  localparam int CH_W  = $clog2(CHAN_N);
  localparam int CNT_W = PTR_W + 1;

  lpc_state_e        state, state_n;
  logic [COL_W-1:0]  col, col_n;
  logic [PTR_W-1:0]  ptr, ptr_n, len, len_n, ptr_inc, len_clamped;
  logic [PTR_W:0]    ptr_p1;
  logic [CNT_W-1:0]  nl_left, nl_n, srch_i, si_n;
  logic              nl_adv, adv_n, ff_pend, ff_n, tof_pend, tof_n;
  logic              chr_cr, cr_n, stop_pend, stop_n;
  logic [COL_W-1:0]  chr_left, chr_n;
  logic [6:0]        chr_code, code_n;
  logic [CH_W-1:0]   srch_ch, sch_n;
  logic              page_dec, page_hit, page_ld;

  lpc_kind_e         d_kind;
  logic              d_pre, d_cr;
  logic [6:0]        d_char;
  logic [COL_W-1:0]  d_rep;

  lpc_char_decode #(
    .COL_W(COL_W), .LINE_COLS(LINE_COLS), .TAB_STOP(TAB_STOP)
  ) u_dec (
    .code(cmd_arg[6:0]), .col(col), .kind(d_kind), .pre_nl(d_pre),
    .emit_char(d_char), .rep(d_rep), .is_cr(d_cr)
  );

  assign page_ld = page_load && (state == S_IDLE);

  lpc_page_ctr #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .load(page_ld), .load_val(page_value),
    .dec(page_dec), .count(page_count), .zero(page_zero),
    .dec_hits_zero(page_hit)
  );

  function automatic lpc_state_e pick(input logic [CNT_W-1:0] n, input logic f,
                                      input logic t, input logic [COL_W-1:0] c);
    if (n != '0)      return S_NL;
    else if (f)       return S_FF;
    else if (t)       return S_TOF;
    else if (c != '0) return S_CHR;
    else              return S_FIN;
  endfunction

  assign ptr_p1      = {1'b0, ptr} + (PTR_W + 1)'(1);
  assign ptr_inc     = (ptr_p1 >= {1'b0, len}) ? '0 : ptr_p1[PTR_W-1:0];
  assign len_clamped = (fmt_len_value > PTR_W'(FMT_DEPTH)) ? PTR_W'(FMT_DEPTH)
                                                           : fmt_len_value;

  assign cmd_ready = (state == S_IDLE);
  assign out_valid = (state == S_NL) || (state == S_FF) || (state == S_CHR);
  assign out_char  = (state == S_NL) ? CH_LF : (state == S_FF) ? CH_FF : chr_code;
  assign stop_req  = (state == S_FIN) && stop_pend;
  assign column    = col;
  assign line_ptr  = ptr;
  assign fmt_len   = len;

  always_comb begin
    state_n = state;  col_n = col;  ptr_n = ptr;  len_n = len;
    nl_n = nl_left;   adv_n = nl_adv;  ff_n = ff_pend;  tof_n = tof_pend;
    chr_n = chr_left; code_n = chr_code; cr_n = chr_cr;
    sch_n = srch_ch;  si_n = srch_i;  stop_n = stop_pend;
    fmt_addr = ptr;
    page_dec = 1'b0;
    case (state)
      S_IDLE: begin
        if (fmt_len_load) begin
          len_n = len_clamped;
          ptr_n = '0;
        end
        if (cmd_valid) begin
          nl_n = '0; adv_n = 1'b0; ff_n = 1'b0; tof_n = 1'b0;
          chr_n = '0; stop_n = 1'b0; si_n = '0;
          case (cmd_op)
            OP_PRINT: begin
              case (d_kind)
                K_NOP: state_n = S_FIN;
                K_LF: begin
                  nl_n = CNT_W'(1); adv_n = 1'b1; tof_n = 1'b1; state_n = S_NL;
                end
                K_FF: begin
                  sch_n = '0; state_n = S_SEARCH;
                end
                default: begin
                  nl_n   = CNT_W'(d_pre);
                  adv_n  = 1'b1;
                  tof_n  = d_pre;
                  chr_n  = d_rep;
                  code_n = d_char;
                  cr_n   = d_cr;
                  state_n = d_pre ? S_NL : S_CHR;
                end
              endcase
            end
            OP_SLEW: begin
              if (cmd_arg == 8'd0) begin
                state_n = S_FIN;
              end else begin
                nl_n = CNT_W'(cmd_arg); adv_n = 1'b1; tof_n = 1'b1; state_n = S_NL;
              end
            end
            OP_SKIP: begin
              sch_n = (cmd_arg > 8'(CHAN_N - 1)) ? CH_W'(FALLBACK_CHAN)
                                                 : CH_W'(cmd_arg);
              state_n = S_SEARCH;
            end
            default: state_n = S_FIN;
          endcase
        end
      end
      S_SEARCH: begin
        if (srch_i >= CNT_W'(len)) begin
          len_n   = '0;
          stop_n  = 1'b1;
          state_n = S_FIN;
        end else begin
          fmt_addr = ptr_inc;
          ptr_n    = ptr_inc;
          if (fmt_row[srch_ch]) begin
            tof_n = 1'b1;
            if (srch_ch == '0) begin
              nl_n = CNT_W'(col != '0);
              ff_n = 1'b1;
            end else begin
              nl_n = srch_i + CNT_W'(1);
            end
            state_n = pick(nl_n, ff_n, 1'b1, chr_left);
          end else begin
            si_n = srch_i + CNT_W'(1);
          end
        end
      end
      S_NL: begin
        if (out_ready) begin
          nl_n  = nl_left - CNT_W'(1);
          col_n = '0;
          if (nl_adv) ptr_n = ptr_inc;
          if (nl_left == CNT_W'(1)) state_n = pick('0, ff_pend, tof_pend, chr_left);
        end
      end
      S_FF: begin
        if (out_ready) begin
          ff_n    = 1'b0;
          state_n = pick('0, 1'b0, tof_pend, chr_left);
        end
      end
      S_TOF: begin
        tof_n = 1'b0;
        if (fmt_row[0]) begin
          page_dec = 1'b1;
          if (page_hit) stop_n = 1'b1;
        end
        state_n = pick('0, 1'b0, 1'b0, chr_left);
      end
      S_CHR: begin
        if (out_ready) begin
          chr_n = chr_left - COL_W'(1);
          col_n = chr_cr ? '0 : col + COL_W'(1);
          if (chr_left == COL_W'(1)) state_n = S_FIN;
        end
      end
      S_FIN: begin
        stop_n  = 1'b0;
        state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;  col <= '0;  ptr <= '0;  len <= '0;
      nl_left <= '0;  nl_adv <= 1'b0;  ff_pend <= 1'b0;  tof_pend <= 1'b0;
      chr_left <= '0;  chr_code <= '0;  chr_cr <= 1'b0;
      srch_ch <= '0;  srch_i <= '0;  stop_pend <= 1'b0;
    end else begin
      state <= state_n;  col <= col_n;  ptr <= ptr_n;  len <= len_n;
      nl_left <= nl_n;  nl_adv <= adv_n;  ff_pend <= ff_n;  tof_pend <= tof_n;
      chr_left <= chr_n;  chr_code <= code_n;  chr_cr <= cr_n;
      srch_ch <= sch_n;  srch_i <= si_n;  stop_pend <= stop_n;
    end
  end

  // R13
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char)));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !out_valid);

  // R13
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);

  // R6
  col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    column <= COL_W'(LINE_COLS));

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_len != '0) |-> (line_ptr < fmt_len));

endmodule

// File: tb/lp_carriage_test.sv
module lp_carriage_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 143;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, out_ready = 1'b0, fmt_len_load = 1'b0, page_load = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [7:0] cmd_arg = '0, fmt_len_value = '0;
  logic [11:0] page_value = '0;
  logic cmd_ready, out_valid, page_zero, stop_req;
  logic [6:0] out_char;
  logic [7:0] fmt_addr, column, line_ptr, fmt_len;
  logic [11:0] fmt_row, page_count;
  logic [11:0] fmt_mem [0:DEPTH-1];

  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fmt_row = (fmt_addr < 8'(DEPTH)) ? fmt_mem[fmt_addr] : 12'h000;

  lp_carriage uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .out_valid(out_valid), .out_ready(out_ready),
    .out_char(out_char), .fmt_addr(fmt_addr), .fmt_row(fmt_row),
    .fmt_len_load(fmt_len_load), .fmt_len_value(fmt_len_value),
    .page_load(page_load), .page_value(page_value), .column(column),
    .line_ptr(line_ptr), .fmt_len(fmt_len), .page_count(page_count),
    .page_zero(page_zero), .stop_req(stop_req)
  );

  // bench model state
  int m_col = 0, m_ptr = 0, m_len = 0, m_page = 0;
  bit m_pz = 0, m_stop = 0;
  int exp_q [0:1023];
  int got_q [0:1023];
  int exp_n = 0, got_n = 0;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL R13 watchdog expired: actual %0d cycles expected below 150000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_wrap(input int p);
    return (p + 1 >= m_len) ? 0 : p + 1;
  endfunction

  task automatic m_push(input int c);
    exp_q[exp_n] = c; exp_n++;
  endtask

  task automatic m_tof();
    if (fmt_mem[m_ptr][0]) begin
      m_page = (m_page - 1) & 12'hFFF;
      if (m_page == 0) begin m_pz = 1; m_stop = 1; end
      else m_pz = 0;
    end
  endtask

  task automatic m_adv(input int n, input bit adv);
    if (n == 0) return;
    m_col = 0;
    for (int k = 0; k < n; k++) begin
      m_push(8'h0A);
      if (adv) m_ptr = m_wrap(m_ptr);
    end
    m_tof();
  endtask

  task automatic m_skip(input int ch_in);
    int ch = (ch_in > 11) ? 7 : ch_in;
    int steps = -1;
    for (int k = 0; k < m_len; k++) begin
      m_ptr = m_wrap(m_ptr);
      if (fmt_mem[m_ptr][ch]) begin steps = k; break; end
    end
    if (steps < 0) begin m_len = 0; m_stop = 1; return; end
    if (ch != 0) m_adv(steps + 1, 0);
    else begin
      if (m_col != 0) begin m_push(8'h0A); m_col = 0; end
      m_push(8'h0C);
      m_tof();
    end
  endtask

  task automatic m_print(input int c_in);
    int c = c_in & 8'h7F;
    int rep;
    if (c == 0) return;
    if (c == 8'h0A) begin m_adv(1, 1); return; end
    if (c == 8'h0C) begin m_skip(0); return; end
    if (c == 8'h0D) begin m_push(c); m_col = 0; return; end
    if (c == 8'h09) begin
      if (m_col >= 128) begin m_adv(1, 1); rep = 8; end
      else rep = 8 - (m_col % 8);
      for (int k = 0; k < rep; k++) m_push(8'h20);
      m_col += rep;
      return;
    end
    if (c < 8'h20) c = 8'h20;
    if (m_col >= 132) m_adv(1, 1);
    m_push(c);
    m_col++;
  endtask

  task automatic load_len(input int v);
    @(negedge clk); fmt_len_load = 1'b1; fmt_len_value = 8'(v);
    @(negedge clk); fmt_len_load = 1'b0;
    m_len = (v > DEPTH) ? DEPTH : v; m_ptr = 0;
  endtask

  task automatic load_page(input int v);
    @(negedge clk); page_load = 1'b1; page_value = 12'(v);
    @(negedge clk); page_load = 1'b0;
    m_page = v;
  endtask

  // run one command, optionally loading the page counter in the same cycle
  task automatic run_cmd(input int op, input int arg, input bit pl, input int pv,
                         input string req);
    bit saw_stop = 0;
    int guard = 0;
    bit same;
    exp_n = 0; got_n = 0; m_stop = 0;
    if (pl) m_page = pv;
    if (op == 0) m_print(arg);
    else if (op == 1) m_adv(arg, 1);
    else if (op == 2) m_skip(arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_arg = 8'(arg);
    page_load = pl; page_value = 12'(pv);
    @(negedge clk);
    cmd_valid = 1'b0; page_load = 1'b0;
    forever begin
      bit r = ($urandom % 4) != 0;
      out_ready = r;
      if (out_valid && r && got_n < 1024) begin got_q[got_n] = out_char; got_n++; end
      if (stop_req) saw_stop = 1;
      if (cmd_ready) break;
      guard++;
      if (guard > 5000) break;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(guard <= 5000, req, "command completion", guard, 0);
    same = (got_n == exp_n);
    for (int k = 0; k < exp_n && same; k++) if (got_q[k] != exp_q[k]) same = 0;
    chk(same, req, "output stream length", got_n, exp_n);
    if (!same) for (int k = 0; k < exp_n && k < got_n; k++)
      if (got_q[k] != exp_q[k]) begin
        chk(0, req, "output char mismatch", got_q[k], exp_q[k]); break;
      end
    chk(column == 8'(m_col), req, "column", column, m_col);
    chk(line_ptr == 8'(m_ptr), req, "line pointer", line_ptr, m_ptr);
    chk(fmt_len == 8'(m_len), req, "format length", fmt_len, m_len);
    chk(page_count == 12'(m_page), req, "page count", page_count, m_page);
    chk(page_zero == m_pz, req, "page_zero", page_zero, m_pz);
    chk(saw_stop == m_stop, req, "stop_req", saw_stop, m_stop);
  endtask

  task automatic fmt_directed();
    for (int k = 0; k < DEPTH; k++) fmt_mem[k] = 12'h000;
    fmt_mem[0] = 12'h003;   // channels 0 and 1
    fmt_mem[3] = 12'h004;   // channel 2
    fmt_mem[6] = 12'h084;   // channels 2 and 7
    fmt_mem[9] = 12'h008;   // channel 3
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    fmt_directed();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(column == 0 && line_ptr == 0 && fmt_len == 0, "R1", "counters after reset",
        {column, line_ptr, fmt_len}, 0);
    chk(page_count == 0 && !page_zero && !stop_req, "R1", "page state after reset",
        {page_count, page_zero, stop_req}, 0);
    chk(cmd_ready && !out_valid, "R1", "handshake after reset",
        {cmd_ready, out_valid}, 2);

    load_len(12);
    load_page(3);
    run_cmd(0, 8'h00, 0, 0, "R3");        // NUL: nothing
    run_cmd(0, 8'h41, 0, 0, "R2");        // 'A'
    run_cmd(0, 8'hC2, 0, 0, "R2");        // masked to 'B'
    run_cmd(0, 8'h05, 0, 0, "R2");        // control -> space
    run_cmd(0, 8'h09, 0, 0, "R5");        // tab from col 3 -> 5 spaces
    run_cmd(0, 8'h09, 0, 0, "R5");        // tab from col 8 -> 8 spaces
    run_cmd(0, 8'h0D, 0, 0, "R4");        // CR
    for (int k = 0; k < 129; k++) run_cmd(0, 8'h78, 0, 0, "R2");
    run_cmd(0, 8'h09, 0, 0, "R5");        // late tab: LF then 8 spaces
    run_cmd(0, 8'h0D, 0, 0, "R4");
    for (int k = 0; k < 132; k++) run_cmd(0, 8'h79, 0, 0, "R2");
    run_cmd(0, 8'h5A, 0, 0, "R6");        // forced wrap before 'Z'
    run_cmd(1, 0, 0, 0, "R7");            // slew 0: no effect
    run_cmd(1, 3, 0, 0, "R7");
    run_cmd(1, 20, 0, 0, "R7");           // wraps the 12-line format
    run_cmd(0, 8'h0A, 0, 0, "R7");        // LF char = slew 1
    run_cmd(0, 8'h41, 0, 0, "R2");
    run_cmd(2, 2, 0, 0, "R9");
    run_cmd(2, 3, 0, 0, "R9");
    run_cmd(2, 13, 0, 0, "R10");          // becomes channel 7
    run_cmd(0, 8'h41, 0, 0, "R2");
    run_cmd(2, 0, 0, 0, "R11");           // column non-zero: LF, FF
    run_cmd(0, 8'h0C, 0, 0, "R11");       // FF char, column zero: only FF
    load_page(1);
    run_cmd(2, 1, 0, 0, "R8");            // lands on row 0: page reaches zero
    run_cmd(1, 12, 0, 0, "R8");           // decrement from 0 wraps to 4095
    run_cmd(2, 11, 0, 0, "R12");          // no row has channel 11
    run_cmd(1, 2, 0, 0, "R12");           // slew with invalid format
    load_len(12);
    run_cmd(1, 12, 1, 1, "R8");           // page load with command, same edge
    run_cmd(1, 12, 1, 2, "R8");

    // randomized phase
    for (int k = 0; k < 12; k++) fmt_mem[k] = 12'($urandom) & 12'h7FE;
    fmt_mem[0] |= 12'h001;
    fmt_mem[7] |= 12'h001;
    load_len(12);
    load_page(4);
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom % 10;
      if (m_len == 0) load_len(8 + $urandom % 5);
      if (n % 37 == 36) begin
        run_cmd(1, 1 + $urandom % 8, 1, 1 + $urandom % 3, "R8");
      end else if (sel < 6) begin
        int c;
        if ($urandom % 3 == 0) begin
          int pick = $urandom % 6;
          c = (pick == 0) ? 8'h00 : (pick == 1) ? 8'h09 : (pick == 2) ? 8'h0A :
              (pick == 3) ? 8'h0C : (pick == 4) ? 8'h0D : 8'h85;
        end else c = $urandom % 256;
        run_cmd(0, c, 0, 0, "R2");
      end else if (sel < 8) begin
        run_cmd(1, $urandom % 16, 0, 0, "R7");
      end else begin
        run_cmd(2, $urandom % 16, 0, 0, "R9");
      end
    end
    summary();
  end

endmodule